// File: doc/BRIEF.md
# Tagged Out-of-Order Response Slave

This block is a memory target that takes single-beat read and write requests. Each request carries a master-chosen tag, a per-request delay and a flag that says whether it must respect ordering. Accepted requests wait in a small table of slots. Each slot counts down its own delay, which models a target whose access time varies. Responses leave through one response channel and always carry the tag of the request they answer. Requests with different tags may finish in any order. Requests that share a tag always finish in the order they were accepted.

Writes deliver their data in a separate data phase that repeats the tag. Data-phase beats pair with outstanding writes strictly oldest first. If the repeated tag differs from the tag of that write, the write completes with an error and leaves memory untouched.

A request marked as needing ordering completes only after every request accepted before it has completed. Its response says that ordering was applied. When every slot is busy, the block refuses new requests.

Top module: `oot_slave`

## Requirements
- R1: After reset, `req_accept` is 1, `rsp_valid` is 0 and `wd_ready` is 0.
- R2: Every response carries the tag of the request it answers.
  - A read returns the memory word at its address, as held when the response is delivered.
  - A write returns data 0 and commits its data to memory when its response is delivered.
  - The memory is cleared to 0 by reset.
- R3: A request accepted with delay value D makes its response visible no earlier than D cycles after the accepting clock edge. On an otherwise idle block it is visible exactly D cycles after that edge.
- R4: Responses for requests that share a tag leave in acceptance order, whatever their delays.
- R5: A request with `req_unordered`=1 may overtake older requests that have different tags. When it becomes ready earlier, its response leaves first.
- R6: A request with `req_unordered`=0 completes only after every previously accepted request has completed. Its response has `rsp_inorder`=1. Responses to requests with `req_unordered`=1 have `rsp_inorder`=0.
- R7: While all DEPTH slots hold outstanding requests, `req_accept` is 0. It returns to 1 after a response retires a slot.
- R8: `wd_ready` is 1 exactly while some accepted write still waits for its data.
  - A data beat is paired with the oldest such write.
  - A write never responds before its data beat.
- R9: If a data beat's tag differs from the tag of the write it pairs with, that write's response has `rsp_err`=1 and memory is unchanged. Otherwise `rsp_err` is 0. Reads always have `rsp_err`=0.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the next cycle still shows `rsp_valid`=1 with the same tag, data, error and ordering flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_tag | input | TAG_W | Master-chosen tag |
| req_unordered | input | 1 | 1 = request needs no ordering against others |
| req_delay | input | LAT_W | Cycles of target delay for this request |
| req_accept | output | 1 | Request taken on this edge when req_valid is 1 |
| wd_valid | input | 1 | Write data beat present |
| wd_tag | input | TAG_W | Tag repeated with the data beat |
| wd_data | input | DATA_W | Write data |
| wd_ready | output | 1 | Data beat taken on this edge when wd_valid is 1 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_data | output | DATA_W | Read data, 0 for writes |
| rsp_err | output | 1 | Write data-phase tag mismatch |
| rsp_inorder | output | 1 | Ordering was applied to this response |

## Verification
The bench sets a long-delay request ahead of a short-delay one in three ways:
- with the same tag, where a block that sorts only by readiness would swap the two read values;
- with different tags, where a block that forces first-in first-out completion would hold back the younger response;
- with an ordered younger request, where a block that ignores the flag would let it jump the queue.

It fills every slot to catch an accept that overwrites a live entry. It holds two writes waiting for data to catch a data beat paired with the wrong write. It sends a mismatched data tag to catch a write committed despite its error. Under random back-pressure it watches for a response that changes while stalled, as happens when a newly ready older slot steals the output.

// File: rtl/oot_pkg.sv
package oot_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } oot_op_e;

    typedef struct packed {
        logic    valid;
        oot_op_e op;
        logic    has_data;
        logic    ordered;
        logic    err;
    } oot_flags_t;

    // A slot can answer once it holds a read, or a write whose data arrived
    function automatic logic slot_complete(oot_flags_t f);
        return f.valid && (f.op == OP_READ || f.has_data);
    endfunction

endpackage

// File: rtl/oot_pick.sv
module oot_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]                   req,
    output logic                           any,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    // Lowest set index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/oot_mem.sv
module oot_mem #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/oot_slave.sv
module oot_slave
    import oot_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_unordered,
    input  logic [LAT_W-1:0]  req_delay,
    output logic              req_accept,
    input  logic              wd_valid,
    input  logic [TAG_W-1:0]  wd_tag,
    input  logic [DATA_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              rsp_inorder
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // Slot storage
    oot_flags_t        fl      [DEPTH];
    logic [TAG_W-1:0]  e_tag   [DEPTH];
    logic [ADDR_W-1:0] e_addr  [DEPTH];
    logic [DATA_W-1:0] e_data  [DEPTH];
    logic [LAT_W-1:0]  e_cnt   [DEPTH];
    logic [DEPTH-1:0]  older   [DEPTH];   // older[i][j]: slot j was accepted before slot i
    logic [DEPTH-1:0]  same_tag[DEPTH];

    logic [DEPTH-1:0] vmask, await_wd, first_wd, elig;
    logic             free_any, wd_any, el_any;
    logic [IW-1:0]    free_idx, wd_idx, el_idx, sel;
    logic             lock;
    logic [IW-1:0]    lock_idx;
    logic             fire;
    logic [DEPTH-1:0] sel_oh;
    logic [DATA_W-1:0] mem_rdata;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
            assign same_tag[i][j] = fl[j].valid && (e_tag[j] == e_tag[i]);
        end
        assign vmask[i]    = fl[i].valid;
        assign await_wd[i] = fl[i].valid && fl[i].op == OP_WRITE && !fl[i].has_data;
        assign first_wd[i] = await_wd[i] && ((older[i] & await_wd) == '0);
        assign elig[i]     = slot_complete(fl[i]) && (e_cnt[i] == '0)
                             && ((older[i] & same_tag[i]) == '0)
                             && (!fl[i].ordered || ((older[i] & vmask) == '0));
    end

    oot_pick #(.N(DEPTH)) u_free (.req(~vmask),  .any(free_any), .idx(free_idx));
    oot_pick #(.N(DEPTH)) u_wd   (.req(first_wd), .any(wd_any),   .idx(wd_idx));
    oot_pick #(.N(DEPTH)) u_rsp  (.req(elig),     .any(el_any),   .idx(el_idx));

    assign req_accept = free_any;
    assign wd_ready   = wd_any;

    // A stalled response keeps its slot so a newly ready slot cannot replace it
    assign sel        = lock ? lock_idx : el_idx;
    assign rsp_valid  = lock || el_any;
    assign fire       = rsp_valid && rsp_ready;
    assign sel_oh     = DEPTH'(1) << sel;

    oot_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (fire && fl[sel].op == OP_WRITE && !fl[sel].err),
        .waddr (e_addr[sel]),
        .wdata (e_data[sel]),
        .raddr (e_addr[sel]),
        .rdata (mem_rdata)
    );

    assign rsp_tag     = e_tag[sel];
    assign rsp_data    = (fl[sel].op == OP_WRITE) ? '0 : mem_rdata;
    assign rsp_err     = fl[sel].err;
    assign rsp_inorder = fl[sel].ordered;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock     <= 1'b0;
            lock_idx <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                fl[i]     <= '0;
                e_tag[i]  <= '0;
                e_addr[i] <= '0;
                e_data[i] <= '0;
                e_cnt[i]  <= '0;
                older[i]  <= '0;
            end
        end else begin
            lock     <= rsp_valid && !rsp_ready;
            lock_idx <= sel;
            for (int i = 0; i < DEPTH; i++) begin
                if (fl[i].valid && e_cnt[i] != '0) e_cnt[i] <= e_cnt[i] - LAT_W'(1);
                if (fire) older[i][sel] <= 1'b0;
            end
            if (fire) fl[sel].valid <= 1'b0;
            if (wd_valid && wd_any) begin
                fl[wd_idx].has_data <= 1'b1;
                fl[wd_idx].err      <= (wd_tag != e_tag[wd_idx]);
                e_data[wd_idx]      <= wd_data;
            end
            if (req_valid && free_any) begin
                fl[free_idx]     <= '{valid: 1'b1, op: oot_op_e'(req_write),
                                      has_data: 1'b0, ordered: !req_unordered, err: 1'b0};
                e_tag[free_idx]  <= req_tag;
                e_addr[free_idx] <= req_addr;
                e_cnt[free_idx]  <= req_delay;
                older[free_idx]  <= vmask & ~(fire ? sel_oh : '0);
            end
        end
    end

    // R3
    rsp_delay_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> e_cnt[sel] == '0);

    // R4
    same_tag_order_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (older[sel] & same_tag[sel]) == '0);

    // R6
    ordered_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_inorder) |-> (older[sel] & vmask) == '0);

    // R7
    alloc_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_accept) |-> !vmask[free_idx]);

    // R8
    data_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && wd_ready) |=> fl[$past(wd_idx)].has_data);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_tag)
            && $stable(rsp_data) && $stable(rsp_err) && $stable(rsp_inorder));
endmodule

// File: tb/sim_oot_slave.sv
`timescale 1ns/1ps
module sim_oot_slave;
    localparam int DEPTH = 4, TAG_W = 3, ADDR_W = 4, DATA_W = 16, LAT_W = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_unordered = 0, req_accept;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0, wd_tag = '0, rsp_tag;
    logic [LAT_W-1:0]  req_delay = '0;
    logic wd_valid = 0, wd_ready, rsp_valid, rsp_ready = 1, rsp_err, rsp_inorder;
    logic [DATA_W-1:0] wd_data = '0, rsp_data;

    always #10 clk = ~clk;   // 50 MHz

    oot_slave #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_tag(req_tag), .req_unordered(req_unordered), .req_delay(req_delay), .req_accept(req_accept),
        .wd_valid(wd_valid), .wd_tag(wd_tag), .wd_data(wd_data), .wd_ready(wd_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_inorder(rsp_inorder));

    typedef struct {
        bit        wr;
        bit [2:0]  tag;
        bit [3:0]  addr;
        bit [15:0] data;
        bit        has_data;
        bit        err;
        bit        unord;
    } item_t;

    item_t     q[$];
    bit [15:0] mm [16];
    bit [2:0]  tag_log[$];
    bit [15:0] dat_log[$];
    bit        err_log[$];
    int  n_cmp = 0, n_bad = 0;
    bit  bp_on = 0;
    bit  done = 0;

    task automatic check(bit ok, string rq, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        tag_log.delete(); dat_log.delete(); err_log.delete();
    endtask

    task automatic issue(bit wr, int tag, int addr, int lat, bit unord);
        item_t it;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_tag = TAG_W'(tag); req_addr = ADDR_W'(addr);
        req_delay = LAT_W'(lat); req_unordered = unord;
        forever begin
            #2;
            if (req_accept) begin
                it = '{wr: wr, tag: 3'(tag), addr: 4'(addr), data: 16'h0,
                       has_data: 1'b0, err: 1'b0, unord: unord};
                q.push_back(it);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic send_data(int tag, int data);
        @(negedge clk);
        wd_valid = 1; wd_tag = TAG_W'(tag); wd_data = DATA_W'(data);
        forever begin
            #2;
            if (wd_ready) begin
                // pair with the oldest write still waiting for data (R8)
                for (int i = 0; i < q.size(); i++) begin
                    if (q[i].wr && !q[i].has_data) begin
                        q[i].has_data = 1;
                        q[i].data     = 16'(data);
                        q[i].err      = (3'(tag) != q[i].tag);
                        break;
                    end
                end
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        wd_valid = 0;
    endtask

    task automatic drain();
        int t = 0;
        while (q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(q.size() == 0, "R2", "all responses delivered, left", q.size(), 0);
    endtask

    // back-pressure driver
    initial begin
        forever begin
            @(negedge clk);
            rsp_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard keyed by tag
    initial begin
        int k;
        item_t it;
        bit prev_stall = 0;
        logic [TAG_W-1:0]  ptag;
        logic [DATA_W-1:0] pdata;
        logic perr, pord;
        forever begin
            @(negedge clk); #2;
            if (!rst && prev_stall) begin
                check(rsp_valid == 1'b1, "R10", "valid held while stalled", rsp_valid, 1);
                check(rsp_tag == ptag && rsp_data == pdata && rsp_err == perr && rsp_inorder == pord,
                      "R10", "response fields held while stalled", {rsp_tag, rsp_data}, {ptag, pdata});
            end
            prev_stall = !rst && rsp_valid && !rsp_ready;
            ptag = rsp_tag; pdata = rsp_data; perr = rsp_err; pord = rsp_inorder;
            if (!rst && rsp_valid && rsp_ready) begin
                k = -1;
                for (int i = 0; i < q.size(); i++) if (k < 0 && q[i].tag == rsp_tag) k = i;
                check(k >= 0, "R2", "response tag matches an outstanding request", rsp_tag, rsp_tag);
                if (k >= 0) begin
                    it = q[k];
                    if (!it.unord) check(k == 0, "R6", "ordered response is the oldest outstanding", k, 0);
                    check(rsp_inorder == !it.unord, "R6", "ordering flag on response", rsp_inorder, !it.unord);
                    if (it.wr) begin
                        check(it.has_data, "R8", "write responded before its data", 0, 1);
                        check(rsp_err == it.err, "R9", "write error flag", rsp_err, it.err);
                        check(rsp_data == 0, "R2", "write response data", rsp_data, 0);
                        if (!it.err) mm[it.addr] = it.data;
                    end else begin
                        check(rsp_err == 0, "R9", "read error flag", rsp_err, 0);
                        check(rsp_data == mm[it.addr], "R2 R4", "read data in per-tag order",
                              rsp_data, mm[it.addr]);
                    end
                    q.delete(k);
                    tag_log.push_back(rsp_tag);
                    dat_log.push_back(rsp_data);
                    err_log.push_back(rsp_err);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int first;
        int wr, tg, ad, lt, un;
        for (int i = 0; i < 16; i++) mm[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        @(negedge clk); #2;
        check(req_accept == 1, "R1", "req_accept after reset", req_accept, 1);
        check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(wd_ready == 0, "R1", "wd_ready after reset", wd_ready, 0);

        // R3 exact delay on idle block
        issue(0, 0, 0, 5, 1);
        first = -1;
        for (int k = 0; k < 10; k++) begin
            #2;
            if (first < 0 && rsp_valid) first = k;
            @(negedge clk);
        end
        check(first == 5, "R3", "cycles from accept edge to response", first, 5);
        drain();

        // R5 different tags overtake
        clear_logs();
        issue(0, 1, 0, 12, 1);
        issue(0, 2, 0, 0, 1);
        drain();
        check(tag_log[0] == 2 && tag_log[1] == 1, "R5", "short request with other tag first",
              {tag_log[0], tag_log[1]}, {3'd2, 3'd1});

        // R4 same tag keeps order
        issue(1, 1, 5, 0, 1); send_data(1, 16'h1111);
        issue(1, 2, 6, 0, 1); send_data(2, 16'h2222);
        drain();
        clear_logs();
        issue(0, 3, 5, 10, 1);
        issue(0, 3, 6, 0, 1);
        drain();
        check(dat_log[0] == 16'h1111 && dat_log[1] == 16'h2222, "R4", "same-tag responses in issue order",
              {dat_log[0], dat_log[1]}, {16'h1111, 16'h2222});

        // R6 ordered request waits for older ones
        clear_logs();
        issue(0, 4, 5, 10, 1);
        issue(0, 5, 6, 0, 0);
        drain();
        check(tag_log[0] == 4, "R6", "ordered request waited for older", tag_log[0], 4);

        // R7 full table
        for (int i = 0; i < DEPTH; i++) issue(0, i, i, 15, 1);
        #2;
        check(req_accept == 0, "R7", "req_accept with every slot busy", req_accept, 0);
        drain();
        @(negedge clk); #2;
        check(req_accept == 1, "R7", "req_accept after retire", req_accept, 1);

        // R8 data pairs with oldest waiting write
        issue(1, 1, 9, 0, 1);
        issue(1, 2, 10, 0, 1);
        repeat (3) @(negedge clk);
        #2;
        check(rsp_valid == 0, "R8", "write without data does not respond", rsp_valid, 0);
        check(wd_ready == 1, "R8", "wd_ready while writes wait", wd_ready, 1);
        send_data(1, 16'hAAAA);
        send_data(2, 16'hBBBB);
        drain();
        clear_logs();
        issue(0, 0, 9, 0, 1);
        issue(0, 0, 10, 0, 1);
        drain();
        check(dat_log[0] == 16'hAAAA && dat_log[1] == 16'hBBBB, "R8", "data paired oldest first",
              {dat_log[0], dat_log[1]}, {16'hAAAA, 16'hBBBB});
        #2;
        check(wd_ready == 0, "R8", "wd_ready with no waiting write", wd_ready, 0);

        // R9 data tag mismatch
        clear_logs();
        issue(1, 6, 11, 0, 1);
        send_data(7, 16'h5555);
        drain();
        check(err_log[0] == 1, "R9", "mismatch gives error response", err_log[0], 1);
        issue(0, 6, 11, 0, 1);
        drain();
        check(dat_log[1] == 16'h0, "R9", "memory unchanged after error write", dat_log[1], 0);

        // random mix under back-pressure (R2 R4 R6 R10)
        bp_on = 1;
        for (int n = 0; n < 150; n++) begin
            wr = $urandom_range(0, 2) == 0;
            tg = $urandom_range(0, 7);
            ad = $urandom_range(0, 15);
            lt = $urandom_range(0, 7);
            un = $urandom_range(0, 3) != 0;
            issue(wr[0], tg, ad, lt, un[0]);
            if (wr != 0) send_data(($urandom_range(0, 7) == 0) ? (tg ^ 1) : tg, $urandom_range(0, 65535));
        end
        drain();
        bp_on = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule